// File: doc/BRIEF.md
# I2C Master Byte Controller

This block is a byte-level I2C master. It is driven through a three-register write port: a data register, a control register and a clock divider register. Software places the address byte in the data register and requests START. The engine then sends that address and moves exactly one byte per command.

After every step the engine raises a pending flag and reports a 3-bit state. It then holds the bus, with SCL pulled low, until the next command arrives. SCL and SDA are open-drain: the block only pulls a line low or releases it. The received data, or the byte last seen on the bus, is visible on the data output at all times.

A read address causes the engine to fetch the first data byte on its own. The acknowledge bit of a received byte is not sent when the byte arrives. It is sent later, and its value depends on the next command: continue answers ACK, while stop or start answers NACK.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the status reads pending = 1 with state idle (status = 4'b0001), both bus lines are released and the data output is 0.
- R2: Status bit 0 is the pending flag and bits 3:1 hold the state: 0 idle, 1 received byte ready, 2 ready to transmit, 3 address not acknowledged, 4 data byte not acknowledged; codes 5 to 7 never appear.
- R3: Register select 0 is data, 1 is control, 2 is divider. In the control register, bit 0 is continue, bit 1 is start and bit 2 is stop, with priority stop > start > continue. Control and data writes take effect only while pending is 1, and an accepted command clears pending on the next cycle.
- R4: START transmits the data register byte as the address, whose bit 0 selects read (1) or write (0). For a write address, an ACK gives state 2 and a NACK gives state 3.
- R5: For a read address that is ACKed, the engine clocks in the first data byte before it stalls. It then reports state 1 with that byte on the data output.
- R6: In state 1, continue sends ACK for the held byte and receives the next one. Stop sends NACK for the held byte and then a STOP condition.
- R7: In state 2, continue sends the data register byte. A slave ACK returns the engine to state 2, and a slave NACK gives state 4.
- R8: Start written in any held state (1 to 4) produces a repeated START and sends the data register byte as the new address. From state 1, the held byte is first answered with NACK.
- R9: A STOP returns the engine to state idle with pending set, and both lines are released.
- R10: With divider value D, each bit spends 2·(D+1) clocks with SCL low and 2·(D+1) clocks with SCL high, so SCL = f_clk / (4·(D+1)).
- R11: SDA changes only while SCL is low, except for START (SDA falls while SCL is high) and STOP (SDA rises while SCL is high). SDA is sampled as SCL rises, and a high ninth bit counts as NACK.
- R12: While pending is set in states 1 to 4, SCL is held low.
- R13: In state idle, control writes without the start bit change nothing on the bus or in the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 data, 1 control, 2 divider |
| reg_wdata | input | 8 | Register write value |
| sda_in | input | 1 | Sampled level of the SDA line |
| data_q | output | 8 | Data register: received byte or last byte seen on the bus |
| status | output | 4 | {state[2:0], pending} |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Any sequencer error shows up on the bus within one bit time, which is 4·(D+1) clocks. A stray SDA edge while SCL is high decodes as a false START or STOP. A wrong bit count or a shifted sample gives a byte or ACK value that does not match, and a badly timed quarter shows up as an SCL high pulse of the wrong width. A wrong state code, or a pending flag that is never set, shows up as soon as the engine stalls: the reported state and data disagree with what the behavioural slave saw, or SCL is not held low during the stall.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;
  localparam int CTL_CONT  = 0;
  localparam int CTL_START = 1;
  localparam int CTL_STOP  = 2;
  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_DIV  = 2'd2;

  typedef enum logic [2:0] {
    MS_IDLE  = 3'd0,
    MS_RXRDY = 3'd1,
    MS_TXRDY = 3'd2,
    MS_ANACK = 3'd3,
    MS_DNACK = 3'd4
  } mstate_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_HOLD, SQ_START, SQ_TX, SQ_RX, SQ_ACK, SQ_STOP
  } seq_e;

  typedef enum logic [1:0] {FW_RX, FW_STOP, FW_START} follow_e;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q >= div);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_we,
  input  logic              data_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              sda_in,
  output logic              busy,
  output logic [BYTE_W-1:0] data_q,
  output logic [3:0]        status,
  output logic              scl_pull,
  output logic              sda_pull
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  seq_e              seq_q, seq_d;
  mstate_e           ms_q, ms_d;
  follow_e           fw_q, fw_d;
  logic [1:0]        qtr_q, qtr_d;
  logic [3:0]        bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              pend_q, pend_d;
  logic              samp_q, samp_d;
  logic              sda_q, sda_d;
  logic              held_q, held_d;
  logic              addr_q, addr_d;
  logic              nack_q, nack_d;

  wire c_stop  = wdata[CTL_STOP];
  wire c_start = wdata[CTL_START];
  wire c_cont  = wdata[CTL_CONT];

  always_comb begin
    seq_d = seq_q; ms_d = ms_q; fw_d = fw_q; qtr_d = qtr_q; bit_d = bit_q;
    sh_d = sh_q; pend_d = pend_q; samp_d = samp_q; sda_d = sda_q;
    held_d = held_q; addr_d = addr_q; nack_d = nack_q;
    if (pend_q) begin
      if (data_we) sh_d = wdata;
      if (cmd_we) begin
        if (seq_q == SQ_IDLE) begin
          if (c_start) begin
            seq_d = SQ_START; held_d = 1'b0; pend_d = 1'b0;
          end
        end else if (ms_q == MS_RXRDY) begin
          if (c_stop || c_start || c_cont) begin
            seq_d  = SQ_ACK; pend_d = 1'b0;
            nack_d = c_stop || c_start;
            fw_d   = c_stop ? FW_STOP : (c_start ? FW_START : FW_RX);
          end
        end else if (c_stop) begin
          seq_d = SQ_STOP; pend_d = 1'b0;
        end else if (c_start) begin
          seq_d = SQ_START; held_d = 1'b1; pend_d = 1'b0;
        end else if (c_cont && ms_q == MS_TXRDY) begin
          seq_d = SQ_TX; addr_d = 1'b0; bit_d = '0; pend_d = 1'b0;
        end
      end
    end else if (tick) begin
      qtr_d = qtr_q + 2'd1;
      if (qtr_q == 2'd1) samp_d = sda_in;
      unique case (seq_q)
        SQ_START: begin
          if (qtr_q == 2'd0) sda_d = 1'b0;
          if (qtr_q == 2'd2) sda_d = 1'b1;
          if (qtr_q == 2'd3) begin seq_d = SQ_TX; addr_d = 1'b1; bit_d = '0; end
        end
        SQ_STOP: begin
          if (qtr_q == 2'd0) sda_d = 1'b1;
          if (qtr_q == 2'd2) sda_d = 1'b0;
          if (qtr_q == 2'd3) begin seq_d = SQ_IDLE; pend_d = 1'b1; ms_d = MS_IDLE; end
        end
        SQ_TX: begin
          if (qtr_q == 2'd0) sda_d = (bit_q < LAST_BIT) ? ~sh_q[BYTE_W-1] : 1'b0;
          if (qtr_q == 2'd3) begin
            if (bit_q < LAST_BIT) begin
              sh_d  = {sh_q[BYTE_W-2:0], samp_q};
              bit_d = bit_q + 4'd1;
            end else begin
              seq_d = SQ_HOLD; pend_d = 1'b1;
              if (samp_q)                 ms_d = addr_q ? MS_ANACK : MS_DNACK;
              else if (addr_q && sh_q[0]) begin seq_d = SQ_RX; pend_d = 1'b0; bit_d = '0; end
              else                        ms_d = MS_TXRDY;
            end
          end
        end
        SQ_RX: begin
          if (qtr_q == 2'd0) sda_d = 1'b0;
          if (qtr_q == 2'd3) begin
            sh_d = {sh_q[BYTE_W-2:0], samp_q};
            if (bit_q == LAST_BIT - 4'd1) begin
              seq_d = SQ_HOLD; pend_d = 1'b1; ms_d = MS_RXRDY;
            end else begin
              bit_d = bit_q + 4'd1;
            end
          end
        end
        SQ_ACK: begin
          if (qtr_q == 2'd0) sda_d = ~nack_q;
          if (qtr_q == 2'd3) begin
            unique case (fw_q)
              FW_STOP:  seq_d = SQ_STOP;
              FW_START: begin seq_d = SQ_START; held_d = 1'b1; end
              default:  begin seq_d = SQ_RX; bit_d = '0; end
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= SQ_IDLE; ms_q <= MS_IDLE; fw_q <= FW_RX; qtr_q <= '0; bit_q <= '0;
      sh_q <= '0; pend_q <= 1'b1; samp_q <= 1'b1; sda_q <= 1'b0;
      held_q <= 1'b0; addr_q <= 1'b0; nack_q <= 1'b0;
    end else begin
      seq_q <= seq_d; ms_q <= ms_d; fw_q <= fw_d; qtr_q <= qtr_d; bit_q <= bit_d;
      sh_q <= sh_d; pend_q <= pend_d; samp_q <= samp_d; sda_q <= sda_d;
      held_q <= held_d; addr_q <= addr_d; nack_q <= nack_d;
    end
  end

  always_comb begin
    unique case (seq_q)
      SQ_IDLE:  scl_pull = 1'b0;
      SQ_HOLD:  scl_pull = 1'b1;
      SQ_START: scl_pull = (qtr_q < 2'd2) && held_q;
      default:  scl_pull = (qtr_q < 2'd2);
    endcase
  end

  assign sda_pull = sda_q;
  assign busy     = !pend_q;
  assign data_q   = sh_q;
  assign status   = {ms_q, pend_q};
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int             DIV_W     = 8,
  parameter logic [DIV_W-1:0] DIV_RESET = DIV_W'(3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              sda_in,
  output logic [BYTE_W-1:0] data_q,
  output logic [3:0]        status,
  output logic              scl_pull,
  output logic              sda_pull
);
  logic [DIV_W-1:0] div_q, div_d;
  logic             busy, tick;

  always_comb begin
    div_d = div_q;
    if (reg_we && reg_sel == SEL_DIV) div_d = reg_wdata[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= DIV_RESET;
    else        div_q <= div_d;
  end

  i2cm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .tick(tick)
  );

  i2cm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cmd_we(reg_we && reg_sel == SEL_CTRL),
    .data_we(reg_we && reg_sel == SEL_DATA),
    .wdata(reg_wdata), .sda_in(sda_in), .busy(busy),
    .data_q(data_q), .status(status), .scl_pull(scl_pull), .sda_pull(sda_pull)
  );
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [1:0] reg_sel,
  input logic [2:0] ctl_bits,
  input logic [3:0] status,
  input logic       scl_pull,
  input logic       sda_pull
);
  assert_state_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status[3:1] <= 3'd4);

  assert_hold_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && status[3:1] != 3'd0) |-> scl_pull);

  assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 4'b0001) |-> (!scl_pull && !sda_pull));

  assert_stop_accepted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd1 && ctl_bits[2] && status[0] && status[3:1] != 3'd0)
      |=> !status[0]);

  assert_idle_ignore_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd1 && !ctl_bits[1] && status == 4'b0001)
      |=> (status == 4'b0001));
endmodule

bind i2c_byte_master i2cm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .ctl_bits(reg_wdata[2:0]), .status(status), .scl_pull(scl_pull), .sda_pull(sda_pull)
);

// File: tb/i2c_byte_master_tb.sv
`timescale 1ns/1ps
module i2c_byte_master_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, reg_we, slv_low;
  logic [1:0] reg_sel;
  logic [7:0] reg_wdata, data_q;
  logic [3:0] status;
  logic       scl_pull, sda_pull, scl_line, sda_line;

  assign scl_line = !scl_pull;
  assign sda_line = !(sda_pull || slv_low);

  i2c_byte_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .sda_in(sda_line), .data_q(data_q), .status(status), .scl_pull(scl_pull), .sda_pull(sda_pull)
  );

  int n_chk = 0, n_bad = 0, div_now = 3;
  bit done = 0;
  int exp_q[$];
  string tag_q[$];

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus events: 'h100 START, 'h200 STOP, else {byte, nack}
  task automatic expect_ev(int v, string req);
    exp_q.push_back(v); tag_q.push_back(req);
  endtask
  task automatic expect_byte(int b, int nack, string req);
    expect_ev(b * 2 + nack, req);
  endtask

  task automatic ev_seen(int v);
    if (exp_q.size() == 0) chk("R11 unexpected bus event", v, -1);
    else begin
      string t = tag_q.pop_front();
      chk(t, v, exp_q.pop_front());
    end
  endtask

  // monitor + behavioural slave (address 0x50)
  logic p_scl = 1, p_sda = 1;
  int   mbits = 0, mval = 0, hi_cnt = 0;
  bit   hi_ok = 0;
  int   s_phase = 0, s_cnt = 0, s_wcnt = 0;
  logic [7:0] s_sh = 0, s_tx = 0;
  bit   s_rd = 0, s_addr = 0, s_mack = 0;
  logic [7:0] slv_tx[$];

  always @(negedge clk) begin
    if (!rst_n) begin
      slv_low <= 1'b0;
    end else begin
      // per-clock reference checks
      if (status[0] && status[3:1] != 0) chk("R12 hold scl", scl_pull, 1);
      if (status == 4'b0001) chk("R9 idle lines", {scl_pull, sda_pull}, 0);
      chk("R2 state code range", (status[3:1] <= 4) ? 1 : 0, 1);
      // monitor
      if (scl_line) hi_cnt++;
      if (p_scl && scl_line && p_sda && !sda_line) begin
        ev_seen('h100); mbits = 0; hi_ok = 0;
        s_phase = 1; s_cnt = 0; s_addr = 1; s_wcnt = 0; slv_low <= 1'b0;
      end else if (p_scl && scl_line && !p_sda && sda_line) begin
        ev_seen('h200); hi_ok = 0; s_phase = 0; slv_low <= 1'b0;
      end
      if (!p_scl && scl_line) begin
        mval = mval * 2 + int'(sda_line); mbits++;
        if (mbits == 9) begin ev_seen(mval & 'h1FF); mbits = 0; mval = 0; end
        hi_cnt = 1; hi_ok = 1;
        if (s_phase == 1) begin s_sh = {s_sh[6:0], sda_line}; s_cnt++; end
        if (s_phase == 4) s_mack = !sda_line;
      end
      if (p_scl && !scl_line) begin
        if (hi_ok) chk("R10 scl high width", hi_cnt, 2 * (div_now + 1));
        hi_ok = 0;
        case (s_phase)
          1: if (s_cnt == 8) begin
               if (s_addr) begin
                 if (s_sh[7:1] == 7'h50) begin slv_low <= 1'b1; s_phase = 2; s_rd = s_sh[0]; end
                 else s_phase = 0;
               end else if (s_wcnt >= 2) s_phase = 0;
               else begin s_wcnt++; slv_low <= 1'b1; s_phase = 2; end
             end
          2: begin
               if (s_rd) begin
                 s_tx = (slv_tx.size() > 0) ? slv_tx.pop_front() : 8'hFF;
                 slv_low <= !s_tx[7]; s_cnt = 1; s_phase = 3;
               end else begin
                 slv_low <= 1'b0; s_phase = 1; s_cnt = 0; s_addr = 0;
               end
             end
          3: if (s_cnt < 8) begin slv_low <= !s_tx[7 - s_cnt]; s_cnt++; end
             else begin slv_low <= 1'b0; s_phase = 4; end
          4: if (s_mack) begin
               s_tx = (slv_tx.size() > 0) ? slv_tx.pop_front() : 8'hFF;
               slv_low <= !s_tx[7]; s_cnt = 1; s_phase = 3;
             end else s_phase = 0;
          default: ;
        endcase
      end
      p_scl = scl_line; p_sda = sda_line;
    end
  end

  task automatic wr(logic [1:0] sel, logic [7:0] val);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic wait_pend();
    @(negedge clk);
    while (!status[0]) @(negedge clk);
  endtask
  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 0; reg_we = 0; reg_sel = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset status", status, 4'b0001);
    chk("R1 reset lines", {scl_pull, sda_pull}, 0);
    chk("R1 reset data", data_q, 0);
    rst_n = 1;
    wr(2, 8'd1); div_now = 1;

    // write two bytes
    expect_ev('h100, "R11 start"); expect_byte('hA0, 0, "R4 write address");
    wr(0, 8'hA0); wr(1, 8'h02);
    chk("R3 pending cleared", status[0], 0);
    wait_pend(); chk("R4 addr ack -> tx ready", status, 4'h5);
    expect_byte('h11, 0, "R7 data byte 1");
    wr(0, 8'h11); wr(1, 8'h01); wait_pend();
    chk("R7 ack -> tx ready", status, 4'h5);
    chk("R7 bus byte in data", data_q, 'h11);
    expect_byte('h22, 0, "R7 data byte 2");
    wr(0, 8'h22); wr(1, 8'h01); wait_pend();
    expect_ev('h200, "R9 stop");
    wr(1, 8'h04); wait_pend();
    chk("R9 idle after stop", status, 4'h1);

    // data NACK on third byte
    expect_ev('h100, "R4 start"); expect_byte('hA0, 0, "R4 addr");
    wr(0, 8'hA0); wr(1, 8'h02); wait_pend();
    for (int i = 1; i <= 3; i++) begin
      expect_byte(i, (i == 3) ? 1 : 0, "R7 data write");
      wr(0, 8'(i)); wr(1, 8'h01); wait_pend();
    end
    chk("R7 data nack -> state 4", status, 4'h9);
    expect_ev('h200, "R9 stop after nack");
    wr(1, 8'h04); wait_pend();

    // address NACK
    expect_ev('h100, "R4 start"); expect_byte('h60, 1, "R4 addr nack");
    wr(0, 8'h60); wr(1, 8'h02); wait_pend();
    chk("R4 addr nack -> state 3", status, 4'h7);
    expect_ev('h200, "R9 stop"); wr(1, 8'h04); wait_pend();
    chk("R9 idle", status, 4'h1);

    // read three bytes
    slv_tx.push_back(8'h5A); slv_tx.push_back(8'hC3); slv_tx.push_back(8'h81);
    expect_ev('h100, "R5 start"); expect_byte('hA1, 0, "R5 read addr");
    wr(0, 8'hA1); wr(1, 8'h02); wait_pend();
    chk("R5 first byte ready", status, 4'h3);
    chk("R5 first byte value", data_q, 'h5A);
    expect_byte('h5A, 0, "R6 ack on continue");
    wr(1, 8'h01); wait_pend();
    chk("R6 second byte", data_q, 'hC3);
    expect_byte('hC3, 0, "R6 ack on continue");
    wr(1, 8'h01); wait_pend();
    chk("R6 third byte", data_q, 'h81);
    chk("R6 state rx ready", status, 4'h3);
    expect_byte('h81, 1, "R6 nack on stop"); expect_ev('h200, "R6 stop");
    wr(1, 8'h04); wait_pend();
    chk("R9 idle after read", status, 4'h1);

    // repeated start: write one byte, then read one
    slv_tx.push_back(8'h3C);
    expect_ev('h100, "R8 start"); expect_byte('hA0, 0, "R8 addr");
    wr(0, 8'hA0); wr(1, 8'h02); wait_pend();
    expect_byte('h07, 0, "R8 data");
    wr(0, 8'h07); wr(1, 8'h01); wait_pend();
    expect_ev('h100, "R8 repeated start"); expect_byte('hA1, 0, "R8 read addr");
    wr(0, 8'hA1); wr(1, 8'h03); wait_pend();
    chk("R8 read after restart", status, 4'h3);
    chk("R8 read byte", data_q, 'h3C);
    expect_byte('h3C, 1, "R8 nack"); expect_ev('h200, "R8 stop");
    wr(1, 8'h04); wait_pend();

    // writes while busy are ignored
    expect_ev('h100, "R3 start"); expect_byte('hA0, 0, "R3 addr");
    wr(0, 8'hA0); wr(1, 8'h02); wait_pend();
    expect_byte('h11, 0, "R3 busy data write ignored");
    wr(0, 8'h11); wr(1, 8'h01);
    wr(0, 8'hEE); wr(1, 8'h04);
    wait_pend();
    chk("R3 busy stop ignored", status, 4'h5);
    chk("R3 data unchanged", data_q, 'h11);
    expect_ev('h200, "R3 stop"); wr(1, 8'h04); wait_pend();

    // idle ignores continue/stop
    wr(1, 8'h05);
    repeat (20) @(negedge clk);
    chk("R13 idle status", status, 4'h1);
    chk("R13 idle lines", {scl_pull, sda_pull}, 0);

    // slower divider
    wr(2, 8'd3); div_now = 3;
    expect_ev('h100, "R10 start"); expect_byte('h60, 1, "R10 addr at div 3");
    wr(0, 8'h60); wr(1, 8'h02); wait_pend();
    expect_ev('h200, "R10 stop"); wr(1, 8'h04); wait_pend();

    repeat (20) @(negedge clk);
    chk("R11 all bus events seen", exp_q.size(), 0);
    finish_run();
  end
endmodule